// File: doc/BRIEF.md
# Parity-Protected Four-Channel FFT Bank

Four independent four-point transform channels run side by side on real, signed samples. A fifth, redundant transform is fed with the sample-by-sample sum of the four channel inputs, so by linearity its spectrum equals the sum of the four channel spectra. Every one of the five transforms has an energy checker. The checker compares four times the input energy with the output energy, using Parseval's relation, and raises a flag when the two differ by more than a tolerance set at a port.

The flags locate a faulty channel, and the redundant spectrum rebuilds it. When exactly one data channel is flagged and the redundant transform is clean, that channel's output is replaced bin by bin with the redundant spectrum minus the other three spectra. When more than one result is in doubt, the outputs pass through unchanged and an uncorrectable indication is raised. Fault-injection inputs flip chosen bits in one bin of any transform, so the bench can exercise detection and repair.

Top module: `pfft_guard`

## Requirements
- R1: Each channel n computes, from samples x0..x3, bin0 = x0+x1+x2+x3, bin1 = (x0-x2) - j(x1-x3), bin2 = x0-x1+x2-x3, bin3 = (x0-x2) + j(x1-x3). Bins 0 and 2 have a zero imaginary part. dout[c][b][0] is the real part and dout[c][b][1] the imaginary part, both W+2 bits in two's complement.
- R2: out_vld rises exactly two clock cycles after a cycle with in_vld high. The results and flags of that transform appear in the same cycle.
- R3: The redundant transform works on input sums two bits wider than a channel sample, and its output is two bits wider again, so full-scale inputs of either sign never overflow.
- R4: A transform's flag is set when |4·Σx² − Σ(re²+im²)| exceeds tol. A clean transform never sets a flag.
- R5: A deviation of at most tol does not set a flag, and the outputs then carry the uncorrected value.
- R6: When exactly one of err[3:0] is set and par_err is clear, that channel's bins equal the redundant spectrum minus the other three channels' bins, and uncorr stays low.
- R7: When two or more of err[3:0] are set, every output is the raw transform result and uncorr is high.
- R8: par_err reports the redundant transform's flag. With par_err alone, outputs are raw and uncorr is low. With par_err and one channel flag, outputs are raw and uncorr is high.
- R9: Fault injection XORs inj_val into the real part of bin1 of each channel selected in inj_ch, and of the redundant transform when inj_par is high, in the transform captured with in_vld.
- R10: During and after reset, before any transform, out_vld, err, par_err and uncorr are low and dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Samples on din are valid this cycle |
| din | input | 4x4xW | Channel c, sample n, signed |
| tol | input | 2(W+4)+4 | Energy mismatch tolerance, unsigned |
| inj_ch | input | 4 | Select channels for fault injection |
| inj_par | input | 1 | Inject into the redundant transform |
| inj_val | input | W+2 | XOR pattern for bin1 real part |
| out_vld | output | 1 | Results valid |
| dout | output | 4x4x2x(W+2) | Channel, bin, {imag, real} |
| err | output | 4 | Per-channel energy flag |
| par_err | output | 1 | Redundant-transform energy flag |
| uncorr | output | 1 | Fault could not be repaired |

## Verification
The bench applies full-scale negative and positive inputs. A design that drops the redundant path's extra width would wrap, which breaks both the rebuilt outputs and the parity sums. It injects into each channel in turn and checks every bin of the repaired channel. An off-by-one in the "other three" sum, or a repair of the wrong channel, shows up as a bin mismatch. Two-channel faults and a faulty redundant transform check that nothing is rewritten when repair is unsafe. Single-LSB faults with a large tolerance and with a zero tolerance check that the comparison is strict and uses the absolute difference.

// File: rtl/pfft_guard.sv
module pfft_guard #(
  parameter int W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_vld,
  input  logic [3:0][3:0][W-1:0]              din,
  input  logic [2*(W+4)+3:0]                  tol,
  input  logic [3:0]                          inj_ch,
  input  logic                                inj_par,
  input  logic [W+1:0]                        inj_val,
  output logic                                out_vld,
  output logic [3:0][3:0][1:0][W+1:0]         dout,
  output logic [3:0]                          err,
  output logic                                par_err,
  output logic                                uncorr
);
  localparam int OW = W + 2;
  localparam int PW = W + 2;
  localparam int FW = W + 4;
  localparam int EW = 2 * FW + 4;

  logic signed [PW-1:0] xs [5][4];
  logic signed [FW-1:0] ra [5][4][2];
  logic [4:0]           flg;
  logic                 a_vld;

  for (genvar n = 0; n < 4; n++) begin : g_in
    for (genvar c = 0; c < 4; c++) begin : g_ch
      assign xs[c][n] = PW'($signed(din[c][n]));
    end
    assign xs[4][n] = xs[0][n] + xs[1][n] + xs[2][n] + xs[3][n];
  end

  for (genvar f = 0; f < 5; f++) begin : g_fft
    logic                 hit;
    logic signed [FW-1:0] y  [4][2];
    logic signed [FW-1:0] ry [4][2];
    logic signed [EW-1:0] ei, eo, rei, reo, dif;

    if (f < 4) begin : g_hc
      assign hit = inj_ch[f];
    end else begin : g_hp
      assign hit = inj_par;
    end

    always_comb begin
      logic signed [FW-1:0] a0, a1, a2, a3, s0, s1, d0, d1;
      a0 = FW'(xs[f][0]);
      a1 = FW'(xs[f][1]);
      a2 = FW'(xs[f][2]);
      a3 = FW'(xs[f][3]);
      s0 = a0 + a2;
      d0 = a0 - a2;
      s1 = a1 + a3;
      d1 = a1 - a3;
      y[0][0] = s0 + s1;
      y[0][1] = '0;
      y[1][0] = hit ? (d0 ^ FW'(inj_val)) : d0;
      y[1][1] = -d1;
      y[2][0] = s0 - s1;
      y[2][1] = '0;
      y[3][0] = d0;
      y[3][1] = d1;
      ei = '0;
      for (int n = 0; n < 4; n++) ei = ei + EW'(xs[f][n]) * EW'(xs[f][n]);
      ei = ei <<< 2;
      eo = '0;
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 2; p++) eo = eo + EW'(y[b][p]) * EW'(y[b][p]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ry  <= '{default: '{default: '0}};
        rei <= '0;
        reo <= '0;
      end else if (in_vld) begin
        ry  <= y;
        rei <= ei;
        reo <= eo;
      end
    end

    assign dif    = rei - reo;
    assign flg[f] = $unsigned(dif[EW-1] ? -dif : dif) > tol;

    for (genvar b = 0; b < 4; b++) begin : g_b
      for (genvar p = 0; p < 2; p++) begin : g_p
        assign ra[f][b][p] = ry[b][p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) a_vld <= 1'b0;
    else        a_vld <= in_vld;
  end

  logic [2:0] nf;
  logic       fix;
  logic [3:0][3:0][1:0][OW-1:0] nxt;

  assign nf  = 3'($countones(flg[3:0]));
  assign fix = (nf == 3'd1) && !flg[4];

  always_comb begin
    logic signed [FW-1:0] rest;
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 2; p++) begin
          rest = ra[4][b][p] - (ra[0][b][p] + ra[1][b][p] + ra[2][b][p] + ra[3][b][p] - ra[c][b][p]);
          nxt[c][b][p] = (fix && flg[c]) ? rest[OW-1:0] : ra[c][b][p][OW-1:0];
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      dout    <= '0;
      err     <= '0;
      par_err <= 1'b0;
      uncorr  <= 1'b0;
    end else begin
      out_vld <= a_vld;
      if (a_vld) begin
        dout    <= nxt;
        err     <= flg[3:0];
        par_err <= flg[4];
        uncorr  <= (nf > 3'd1) || ((nf == 3'd1) && flg[4]);
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> $past(in_vld, 2));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> (ra[4][0][0] == ra[0][0][0] + ra[1][0][0] + ra[2][0][0] + ra[3][0][0])
           && (ra[4][2][0] == ra[0][2][0] + ra[1][2][0] + ra[2][2][0] + ra[3][2][0]));

  a_r7_unc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> ($countones(err) >= 2) || par_err);

  a_r8_clean_no_unc: assert property (@(posedge clk) disable iff (!rst_n)
    (err == 4'd0) |-> !uncorr);

  a_r6_single_fixable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $countones(err) == 1 && !par_err) |-> !uncorr);
endmodule

// File: tb/sim_pfft_guard.sv
`timescale 1ns/1ps
module sim_pfft_guard;
  localparam int W  = 8;
  localparam int OW = W + 2;
  localparam int EW = 2 * (W + 4) + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [3:0][3:0][W-1:0] din = '0;
  logic [EW-1:0] tol = '0;
  logic [3:0] inj_ch = '0;
  logic inj_par = 1'b0;
  logic [OW-1:0] inj_val = '0;
  logic out_vld;
  logic [3:0][3:0][1:0][OW-1:0] dout;
  logic [3:0] err;
  logic par_err, uncorr;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  pfft_guard #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .din(din), .tol(tol),
    .inj_ch(inj_ch), .inj_par(inj_par), .inj_val(inj_val),
    .out_vld(out_vld), .dout(dout), .err(err), .par_err(par_err), .uncorr(uncorr));

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic frame(input string tag, input int x[4][4], input logic [3:0] ich,
                       input bit ip, input int iv, input longint tv);
    longint xin[5][4];
    longint y[5][4][2];
    longint ei, eo, d, rest;
    bit fl[5];
    int nf, bad;
    longint e;
    logic [OW-1:0] ev;
    bit hit;
    for (int n = 0; n < 4; n++) begin
      xin[4][n] = 0;
      for (int c = 0; c < 4; c++) begin
        xin[c][n] = x[c][n];
        xin[4][n] += x[c][n];
      end
    end
    for (int f = 0; f < 5; f++) begin
      hit = (f < 4) ? ich[f] : ip;
      y[f][0][0] = xin[f][0] + xin[f][1] + xin[f][2] + xin[f][3];
      y[f][0][1] = 0;
      y[f][1][0] = xin[f][0] - xin[f][2];
      if (hit) y[f][1][0] = y[f][1][0] ^ longint'(iv);
      y[f][1][1] = -(xin[f][1] - xin[f][3]);
      y[f][2][0] = xin[f][0] - xin[f][1] + xin[f][2] - xin[f][3];
      y[f][2][1] = 0;
      y[f][3][0] = xin[f][0] - xin[f][2];
      y[f][3][1] = xin[f][1] - xin[f][3];
      ei = 0;
      eo = 0;
      for (int n = 0; n < 4; n++) ei += xin[f][n] * xin[f][n];
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 2; p++) eo += y[f][b][p] * y[f][b][p];
      d = 4 * ei - eo;
      if (d < 0) d = -d;
      fl[f] = d > tv;
    end
    nf = int'(fl[0]) + int'(fl[1]) + int'(fl[2]) + int'(fl[3]);

    @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) din[c][n] = W'(x[c][n]);
    tol = EW'(tv);
    inj_ch = ich;
    inj_par = ip;
    inj_val = OW'(iv);
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    inj_ch = '0;
    inj_par = 1'b0;
    chk({tag, " R2"}, "out_vld one cycle after input", longint'(out_vld), 0);
    @(negedge clk);
    chk({tag, " R2"}, "out_vld two cycles after input", longint'(out_vld), 1);
    chk({tag, " R4"}, "err", longint'(err), longint'({fl[3], fl[2], fl[1], fl[0]}));
    chk({tag, " R8"}, "par_err", longint'(par_err), longint'(fl[4]));
    chk({tag, " R7"}, "uncorr", longint'(uncorr), longint'((nf > 1) || (nf == 1 && fl[4])));
    for (int c = 0; c < 4; c++) begin
      bad = 0;
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 2; p++) begin
          e = y[c][b][p];
          if (nf == 1 && !fl[4] && fl[c]) begin
            rest = y[4][b][p];
            for (int k = 0; k < 4; k++) if (k != c) rest -= y[k][b][p];
            e = rest;
          end
          ev = OW'(e);
          if (dout[c][b][p] !== ev) begin
            bad++;
            $display("FAIL %s R1/R6 ch%0d bin%0d part%0d: got %0d expected %0d",
                     tag, c, b, p, dout[c][b][p], ev);
          end
        end
      compared++;
      if (bad != 0) mismatched++;
    end
  endtask

  task automatic t_reset;
    chk("R10", "out_vld after reset", longint'(out_vld), 0);
    chk("R10", "err after reset", longint'(err), 0);
    chk("R10", "par_err after reset", longint'(par_err), 0);
    chk("R10", "uncorr after reset", longint'(uncorr), 0);
    chk("R10", "dout after reset nonzero", longint'(dout != '0), 0);
  endtask

  task automatic t_clean;
    int x[4][4];
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) x[c][n] = 10 * c + 3 * n - 17;
    frame("R1 ramp", x, 4'b0, 1'b0, 0, 0);
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) x[c][n] = -128;
    frame("R3 full-scale negative", x, 4'b0, 1'b0, 0, 0);
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) x[c][n] = (n % 2 == 0) ? 127 : -128;
    frame("R3 alternating extremes", x, 4'b0, 1'b0, 0, 0);
  endtask

  task automatic t_single;
    int x[4][4];
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) x[c][n] = ((c + 1) * (n + 5) * 37) % 200 - 100;
    for (int k = 0; k < 4; k++)
      frame("R6 R9 single channel fault", x, 4'(1 << k), 1'b0, 8, 0);
    frame("R6 R3 top-bit fault", x, 4'b0100, 1'b0, 1 << (OW - 1), 0);
  endtask

  task automatic t_multi;
    int x[4][4];
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) x[c][n] = 50 - 7 * c * n;
    frame("R7 two channel fault", x, 4'b0101, 1'b0, 12, 0);
    frame("R7 four channel fault", x, 4'b1111, 1'b0, 5, 0);
    frame("R8 parity only fault", x, 4'b0000, 1'b1, 16, 0);
    frame("R8 parity plus one channel", x, 4'b0010, 1'b1, 16, 0);
  endtask

  task automatic t_tol;
    int x[4][4];
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) x[c][n] = 9 * n - 4 * c + 1;
    frame("R5 small fault under tolerance", x, 4'b1000, 1'b0, 1, 100000);
    frame("R4 small fault zero tolerance", x, 4'b1000, 1'b0, 1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_multi();
    t_tol();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule